// File: doc/BRIEF.md
# Split Timer with Toggle and PWM Outputs

This block is a timer built from two 8-bit counter halves that share one programmable prescaler. The halves can run separately or chain into one 16-bit counter. Each half drives one output pin, `outLo` or `outHi`. Depending on the mode, a pin carries a square wave that inverts at each period match or an 8-bit pulse-width-modulated waveform. Each half also pulses an interrupt line once per period.

Software configures the timer through a narrow write-only register port. The writable values are a control byte, the prescaler divisor, a period for each half and a duty value for each half. While a half is running, period and duty writes go to shadow registers. The live values are only replaced at the next period boundary, so the waveform never shows a partly updated cycle. The low half, or the 16-bit counter, can count rising edges on an event input instead of prescaler ticks. The high pin can be switched to a plain beeper square wave.

Top module: `tpw_top`

## Requirements
- R1: Out of reset, `outLo`, `outHi`, `irqLo` and `irqHi` are all low and both halves are stopped.
- R2: A prescaler divisor D gives one count tick every D+1 clocks while either half runs. A stopped half holds its counter at zero, drives its pin low and never pulses its interrupt, starting from the second clock edge after the stop.
- R3: Mode 0 (split timers): each half counts from 0 up to its period P. On the tick at which it sits at P, the half returns to 0, inverts its pin and pulses its interrupt for one clock. Both pins start low.
- R4: With the event bit set in mode 0 or mode 2, the low half (or the 16-bit counter) advances once per rising edge of `evtIn`, and a level held high counts once. In mode 0 the high half keeps counting prescaler ticks.
- R5: Mode 1 (dual PWM): each half counts 0..255 freely. Its pin is high while the count is below its duty value, so duty 0 is constant low and 8'hFF is high for 255 of 256 counts. The half's interrupt pulses at each wrap.
- R6: Mode 2 (16-bit timer): the counter {high,low} runs from 0 to {perHi,perLo}. At the full match `outHi` inverts and `irqHi` pulses. `outLo` inverts and `irqLo` pulses on every tick where the low byte equals perLo.
- R7: Mode 3 (16-bit with PWM): the frame is (perHi+1)*256 ticks. `outLo` is high while the low byte is below the low duty value. `irqLo` pulses at each low-byte wrap. `outHi` inverts and `irqHi` pulses at each full-frame wrap.
- R8: A period or duty written while a half runs takes effect only from the next period boundary of that half. A value written while the half is stopped is in force from the first count.
- R9: With the beeper bit set, `outHi` is a square wave that inverts on every prescaler tick, whatever the mode.
- R10: Write addresses: 0 control, 1 prescaler, 2 low period, 3 high period, 4 low duty, 5 high duty; 6 and 7 are ignored. Control bits: [1:0] mode, [2] run low half or 16-bit counter, [3] run high half (split modes only), [4] event counting, [5] beeper.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| evtIn | input | 1 | External event input, counted on rising edges |
| outLo | output | 1 | Low-half output pin |
| outHi | output | 1 | High-half or beeper output pin |
| irqLo | output | 1 | Low-half period interrupt pulse |
| irqHi | output | 1 | High-half period interrupt pulse |

## Verification
The bench uses the default 8-bit halves and 8-bit prescaler. This makes the whole 256-count PWM frame and several 16-bit frames short enough to run from end to end. Divisors 0 to 2 and small periods make a near-exhaustive sweep of split-mode periods against prescaler phases affordable. The bench predicts every pin and interrupt each cycle by arithmetic on the number of ticks since start. This covers where low-byte matches fall inside a 16-bit frame and which PWM frame a buffered duty write lands in.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'd0,
    MODE_DUALPWM = 2'd1,
    MODE_WIDE    = 2'd2,
    MODE_WIDEPWM = 2'd3
  } tmrMode_e;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_PRE     = 3'd1;
  localparam logic [2:0] ADDR_PER_LO  = 3'd2;
  localparam logic [2:0] ADDR_PER_HI  = 3'd3;
  localparam logic [2:0] ADDR_DUTY_LO = 3'd4;
  localparam logic [2:0] ADDR_DUTY_HI = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    tmrMode_e mode;
    logic     tickLo;   // advance low half / 16-bit counter
    logic     tickHi;   // advance high half (split modes)
    logic     clrLo;    // low half (or 16-bit counter) stopped
    logic     clrHi;    // high half stopped
  } tmrStrobe_t;

endpackage

// File: rtl/tpw_ctrl.sv
module tpw_ctrl
  import tpw_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtIn,
  output tmrStrobe_t        st,
  output logic [HALF_W-1:0] perShLo,
  output logic [HALF_W-1:0] perShHi,
  output logic [HALF_W-1:0] dutyShLo,
  output logic [HALF_W-1:0] dutyShHi,
  output logic              beepOn,
  output logic              beepWave
);

  tmrMode_e         modeR;
  logic             runLoR, runHiR, evtSelR, beepR;
  logic [PRE_W-1:0] preDiv, preCnt;
  logic             evtPrev, beepFf;

  logic actLo, actHi, preOn, preTick, evtRise, useEvt, wide;

  assign wide    = modeR[1];
  assign actLo   = runLoR;
  assign actHi   = runHiR & ~wide;
  assign preOn   = actLo | actHi;
  assign preTick = preOn && (preCnt == preDiv);
  assign evtRise = evtIn & ~evtPrev;
  assign useEvt  = evtSelR & ~modeR[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR    <= MODE_SPLIT;
      runLoR   <= 1'b0;
      runHiR   <= 1'b0;
      evtSelR  <= 1'b0;
      beepR    <= 1'b0;
      preDiv   <= '0;
      perShLo  <= '0;
      perShHi  <= '0;
      dutyShLo <= '0;
      dutyShHi <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          modeR   <= tmrMode_e'(wrData[1:0]);
          runLoR  <= wrData[2];
          runHiR  <= wrData[3];
          evtSelR <= wrData[4];
          beepR   <= wrData[5];
        end
        ADDR_PRE:     preDiv   <= wrData[PRE_W-1:0];
        ADDR_PER_LO:  perShLo  <= wrData[HALF_W-1:0];
        ADDR_PER_HI:  perShHi  <= wrData[HALF_W-1:0];
        ADDR_DUTY_LO: dutyShLo <= wrData[HALF_W-1:0];
        ADDR_DUTY_HI: dutyShHi <= wrData[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  // prescaler, event edge detector, beeper divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      evtPrev <= 1'b0;
      beepFf  <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      if (!preOn) begin
        preCnt <= '0;
        beepFf <= 1'b0;
      end else if (preTick) begin
        preCnt <= '0;
        beepFf <= ~beepFf;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st.mode   = modeR;
    st.tickLo = actLo & (useEvt ? evtRise : preTick);
    st.tickHi = actHi & preTick;
    st.clrLo  = ~actLo;
    st.clrHi  = ~actHi;
  end

  assign beepOn   = beepR;
  assign beepWave = beepFf;

endmodule

// File: rtl/tpw_datapath.sv
module tpw_datapath
  import tpw_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        st,
  input  logic [HALF_W-1:0] perShLo,
  input  logic [HALF_W-1:0] perShHi,
  input  logic [HALF_W-1:0] dutyShLo,
  input  logic [HALF_W-1:0] dutyShHi,
  input  logic              beepOn,
  input  logic              beepWave,
  output logic              outLo,
  output logic              outHi,
  output logic              irqLo,
  output logic              irqHi,
  output logic [HALF_W-1:0] cntLoO,
  output logic [HALF_W-1:0] perActLoO,
  output logic [HALF_W-1:0] dutyActLoO
);

  localparam int WIDE_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] TOP = '1;

  logic [HALF_W-1:0] cntLo, cntHi, perActLo, perActHi, dutyActLo, dutyActHi;
  logic              togLo, togHi;
  logic              wide, pwmMode;
  logic [HALF_W-1:0] limLo, limHi, fullLimLo;
  logic [WIDE_W-1:0] cntW, cntWNext;
  logic              lowEvt, fullHit;

  assign wide      = st.mode[1];
  assign pwmMode   = st.mode[0];
  assign limLo     = pwmMode ? TOP : perActLo;
  assign limHi     = pwmMode ? TOP : perActHi;
  assign fullLimLo = pwmMode ? TOP : perActLo;
  assign cntW      = {cntHi, cntLo};
  assign cntWNext  = cntW + 1'b1;
  assign lowEvt    = (cntLo == fullLimLo);
  assign fullHit   = (cntW == {perActHi, fullLimLo});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0; cntHi <= '0;
      perActLo <= '0; perActHi <= '0;
      dutyActLo <= '0; dutyActHi <= '0;
      togLo <= 1'b0; togHi <= 1'b0;
      irqLo <= 1'b0; irqHi <= 1'b0;
    end else begin
      irqLo <= 1'b0;
      irqHi <= 1'b0;
      if (!wide) begin
        // low half on its own
        if (st.clrLo) begin
          cntLo <= '0; togLo <= 1'b0;
          perActLo <= perShLo; dutyActLo <= dutyShLo;
        end else if (st.tickLo) begin
          if (cntLo == limLo) begin
            cntLo <= '0; togLo <= ~togLo; irqLo <= 1'b1;
            perActLo <= perShLo; dutyActLo <= dutyShLo;
          end else begin
            cntLo <= cntLo + 1'b1;
          end
        end
        // high half on its own
        if (st.clrHi) begin
          cntHi <= '0; togHi <= 1'b0;
          perActHi <= perShHi; dutyActHi <= dutyShHi;
        end else if (st.tickHi) begin
          if (cntHi == limHi) begin
            cntHi <= '0; togHi <= ~togHi; irqHi <= 1'b1;
            perActHi <= perShHi; dutyActHi <= dutyShHi;
          end else begin
            cntHi <= cntHi + 1'b1;
          end
        end
      end else begin
        // halves chained into one counter
        if (st.clrLo) begin
          cntLo <= '0; cntHi <= '0; togLo <= 1'b0; togHi <= 1'b0;
          perActLo <= perShLo; perActHi <= perShHi;
          dutyActLo <= dutyShLo; dutyActHi <= dutyShHi;
        end else if (st.tickLo) begin
          if (fullHit) begin
            {cntHi, cntLo} <= '0;
            togHi <= ~togHi; irqHi <= 1'b1;
            perActLo <= perShLo; perActHi <= perShHi; dutyActHi <= dutyShHi;
          end else begin
            {cntHi, cntLo} <= cntWNext;
          end
          if (lowEvt) begin
            irqLo <= 1'b1;
            if (pwmMode) dutyActLo <= dutyShLo;
            else         togLo <= ~togLo;
          end
        end
      end
    end
  end

  logic pwmLo, pwmHi;
  assign pwmLo = ~st.clrLo && (cntLo < dutyActLo);
  assign pwmHi = ~st.clrHi && (cntHi < dutyActHi);

  assign outLo = pwmMode ? pwmLo : togLo;
  assign outHi = beepOn ? beepWave : ((st.mode == MODE_DUALPWM) ? pwmHi : togHi);

  assign cntLoO     = cntLo;
  assign perActLoO  = perActLo;
  assign dutyActLoO = dutyActLo;

endmodule

// File: rtl/tpw_top.sv
module tpw_top
  import tpw_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8,
  localparam int DATA_W = (HALF_W > PRE_W) ? HALF_W : PRE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtIn,
  output logic              outLo,
  output logic              outHi,
  output logic              irqLo,
  output logic              irqHi
);

  tmrStrobe_t        st;
  logic [HALF_W-1:0] perShLo, perShHi, dutyShLo, dutyShHi;
  logic              beepOn, beepWave;
  logic [HALF_W-1:0] cntLo, perActLo, dutyActLo;

  tpw_ctrl #(.HALF_W(HALF_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtIn(evtIn), .st(st), .perShLo(perShLo), .perShHi(perShHi),
    .dutyShLo(dutyShLo), .dutyShHi(dutyShHi), .beepOn(beepOn), .beepWave(beepWave)
  );

  tpw_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .perShLo(perShLo), .perShHi(perShHi),
    .dutyShLo(dutyShLo), .dutyShHi(dutyShHi), .beepOn(beepOn), .beepWave(beepWave),
    .outLo(outLo), .outHi(outHi), .irqLo(irqLo), .irqHi(irqHi),
    .cntLoO(cntLo), .perActLoO(perActLo), .dutyActLoO(dutyActLo)
  );

endmodule

// File: rtl/tpw_checker.sv
module tpw_checker
  import tpw_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input tmrStrobe_t        st,
  input logic [HALF_W-1:0] cntLo,
  input logic [HALF_W-1:0] perActLo,
  input logic [HALF_W-1:0] dutyActLo,
  input logic              outLo,
  input logic              irqLo,
  input logic              irqHi
);

  assert_split_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.mode == MODE_SPLIT && !st.clrLo && irqLo) |-> (outLo != $past(outLo)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.mode == MODE_SPLIT && $past(st.mode) == MODE_SPLIT) |-> (cntLo <= perActLo));

  assert_stopped_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.clrLo |=> !irqLo);

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.mode == MODE_DUALPWM && dutyActLo == '0) |-> !outLo);

  assert_frame_wrap_lowwrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.mode == MODE_WIDEPWM && irqHi) |-> irqLo);

endmodule

bind tpw_top tpw_checker #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .st(st), .cntLo(cntLo), .perActLo(perActLo),
  .dutyActLo(dutyActLo), .outLo(outLo), .irqLo(irqLo), .irqHi(irqHi)
);

// File: tb/test_tpw_top.sv
module test_tpw_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       evtIn = 1'b0;
  logic       outLo, outHi, irqLo, irqHi;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tpw_top i_tpw_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtIn(evtIn), .outLo(outLo), .outHi(outHi), .irqLo(irqLo), .irqHi(irqHi)
  );

  // order of the 4-bit vectors: {outLo, outHi, irqLo, irqHi}
  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s t=%0t {outLo,outHi,irqLo,irqHi} actual=%b expected=%b",
               req, $time, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write
  task automatic wr(int a, int d);
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int matchCnt(int x, int perLo);
    return (x > perLo) ? ((x - 1 - perLo) / 256 + 1) : 0;
  endfunction

  task automatic runCase(string req, int mode, int pre, int pL, int pH, int dL, int dH,
                         bit runHi, bit evtSel, bit beep, int cycles, int wrAt, int newDL);
    int nLo;
    int L;
    bit eLo, eHi, iLo, iHi, tickLo, tickP;
    int nP, dEff, total;
    wr(0, mode);
    wr(1, pre); wr(2, pL); wr(3, pH); wr(4, dL); wr(5, dH);
    wr(6, 8'hFF); wr(7, 8'hFF);                 // R10: ignored addresses
    evtIn = 1'b0;
    @(negedge clk);
    wr(0, mode | 4 | (int'(runHi) << 3) | (int'(evtSel) << 4) | (int'(beep) << 5));
    nLo = 0;
    for (int e = 1; e <= cycles; e++) begin
      evtIn = evtSel && (e % 5 == 1 || e % 5 == 2);
      if (wrAt == e) begin wrEn = 1'b1; wrAddr = 3'd4; wrData = newDL[7:0]; end
      @(negedge clk);
      wrEn = 1'b0;
      tickP  = (e % (pre + 1) == 0);
      nP     = e / (pre + 1);
      tickLo = evtSel ? (e % 5 == 1) : tickP;
      if (tickLo) nLo++;
      eLo = 0; eHi = 0; iLo = 0; iHi = 0;
      case (mode)
        0: begin
          L = pL + 1;
          eLo = ((nLo / L) % 2) == 1;
          iLo = tickLo && nLo > 0 && (nLo % L == 0);
          if (runHi) begin
            eHi = ((nP / (pH + 1)) % 2) == 1;
            iHi = tickP && nP > 0 && (nP % (pH + 1) == 0);
          end
        end
        1: begin
          dEff = dL;
          if (wrAt > 0 && (e / (256 * (pre + 1))) > (wrAt / (256 * (pre + 1)))) dEff = newDL;
          eLo = (nLo % 256) < dEff;
          iLo = tickLo && nLo > 0 && (nLo % 256 == 0);
          if (runHi) begin
            eHi = (nP % 256) < dH;
            iHi = tickP && nP > 0 && (nP % 256 == 0);
          end
        end
        2: begin
          L = pH * 256 + pL + 1;
          eHi = ((nLo / L) % 2) == 1;
          iHi = tickLo && nLo > 0 && (nLo % L == 0);
          total = (nLo / L) * matchCnt(L, pL) + matchCnt(nLo % L, pL);
          eLo = (total % 2) == 1;
          iLo = tickLo && nLo > 0 && ((((nLo - 1) % L) % 256) == pL);
        end
        default: begin
          L = (pH + 1) * 256;
          eLo = (nLo % 256) < dL;
          eHi = ((nLo / L) % 2) == 1;
          iHi = tickLo && nLo > 0 && (nLo % L == 0);
          iLo = tickLo && nLo > 0 && (nLo % 256 == 0);
        end
      endcase
      if (beep) eHi = (nP % 2) == 1;
      check(req, {outLo, outHi, irqLo, irqHi}, {eLo, eHi, iLo, iHi});
    end
    evtIn = 1'b0;
    wr(0, mode);                                 // stop
    @(negedge clk);
    check("R2 stopped outputs", {outLo, outHi, irqLo, irqHi}, 4'b0000);
    repeat (3) begin
      @(negedge clk);
      check("R2 stopped stays quiet", {outLo, outHi, irqLo, irqHi}, 4'b0000);
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {outLo, outHi, irqLo, irqHi}, 4'b0000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", {outLo, outHi, irqLo, irqHi}, 4'b0000);

    // R3 and R2: split toggles, swept over periods and divisors
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < 3; d++)
        runCase("R3/R2 split sweep", 0, d, p, p + 2, 0, 0, 1, 0, 0, 120, 0, 0);

    // R4: event counting
    runCase("R4 split events", 0, 1, 3, 4, 0, 0, 1, 1, 0, 200, 0, 0);
    runCase("R4 wide events", 2, 0, 2, 0, 0, 0, 0, 1, 0, 100, 0, 0);

    // R5: dual PWM boundary duties
    runCase("R5 duty 0/FF", 1, 0, 0, 0, 8'h00, 8'hFF, 1, 0, 0, 600, 0, 0);
    runCase("R5 duty 1/128", 1, 0, 0, 0, 8'h01, 8'h80, 1, 0, 0, 600, 0, 0);
    runCase("R5 duty FF/0", 1, 0, 0, 0, 8'hFF, 8'h00, 1, 0, 0, 600, 0, 0);
    runCase("R5 prescaled", 1, 1, 0, 0, 8'h40, 8'h03, 1, 0, 0, 1100, 0, 0);

    // R6: 16-bit timer
    runCase("R6 wide long", 2, 0, 8'h20, 1, 0, 0, 0, 0, 0, 800, 0, 0);
    runCase("R6 wide short", 2, 1, 5, 0, 0, 0, 0, 0, 0, 200, 0, 0);
    runCase("R6 wide mid", 2, 0, 7, 2, 0, 0, 0, 0, 0, 1300, 0, 0);

    // R7: 16-bit with PWM low byte
    runCase("R7 wide pwm", 3, 0, 0, 1, 100, 0, 0, 0, 0, 1200, 0, 0);
    runCase("R7 wide pwm FF", 3, 1, 0, 0, 8'hFF, 0, 0, 0, 0, 1200, 0, 0);

    // R8: buffered duty update lands at next wrap
    runCase("R8 buffered duty", 1, 0, 0, 0, 32, 10, 1, 0, 0, 800, 100, 200);

    // R9: beeper
    runCase("R9 beeper", 0, 2, 4, 3, 0, 0, 1, 0, 1, 100, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule